// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a synchronous host and an external asynchronous static RAM of 262,144 sixteen-bit words. The host hands over one transfer at a time on a ready/valid port: an 18-bit word address, write data, a two-bit lane mask and a direction flag. The controller then drives the RAM's strobes for the required number of clock cycles. These are two chip selects of opposite polarity, an output enable, a write enable and one active-low enable per byte lane. It ends each transfer with a one-cycle completion pulse, and a read returns its data with that pulse.

Every analog timing minimum is a nanosecond parameter. Each one is turned into a cycle count by rounding up against the clock period, which defaults to 10 ns. With the default figures, every access keeps the RAM selected for ten cycles, and completion follows in the eleventh cycle after the request was taken. Writes are ended by the write strobe. The controller's own data driver is switched on only after the write strobe has fallen, so it can never fight the RAM's outputs. Between transfers the RAM is deselected and sits in standby.

The data bus is split into an output value, an output-enable and an input value, so the bidirectional pad can be placed at chip level.

Top module: `sram_ctrl`

## Requirements
- R1: While idle and while in reset, the RAM is in standby and the controller is passive. This means ready=1, mem_ce1_n=1, mem_ce2=0, mem_oe_n=1, mem_we_n=1, mem_dq_oe=0 and mem_be_n=2'b11.
- R2: A request is taken at a rising edge where req_valid and req_ready are both 1. Ready then stays 0 through the completion cycle and returns to 1 in the following cycle. A req_valid pulse while ready is 0 is ignored: it produces no completion and changes no RAM word.
- R3: A read keeps mem_ce1_n=0, mem_ce2=1, mem_oe_n=0 and mem_we_n=1 for RD_LEN cycles, which is 10 by default. It presents the latched address for the whole access. It drives mem_be_n to the inverse of the mask: mask bit 1 enables data bits 15..8 and mask bit 0 enables data bits 7..0.
- R4: Read data is sampled at the edge that ends the last access cycle. It is returned on rsp_rdata with rsp_done in the eleventh cycle after acceptance. A lane whose mask bit is 0 returns zero.
- R5: A write holds mem_we_n=0 for WR_LEN cycles. WR_LEN is the largest of the write-pulse count, the address-to-end count and the data-setup count plus one; this gives 8 by default. mem_oe_n stays 1 for the entire write.
- R6: The data driver mem_dq_oe turns on in the cycle after mem_we_n falls. It stays on through the first cycle after mem_we_n rises and is off otherwise. The data is therefore driven for at least the data-setup count before the write ends.
- R7: During a write, chip select and address stay active for 10 cycles by default, covering the write cycle time, with a recovery tail after mem_we_n rises. Completion follows in the eleventh cycle after acceptance.
- R8: A write changes only the byte lanes whose mask bit is 1. The other lanes of the RAM word keep their previous contents.
- R9: rsp_done is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request strobe |
| req_ready | output | 1 | Controller can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 1 = bits 15..8, bit 0 = bits 7..0 |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_done |
| mem_addr | output | 18 | RAM address |
| mem_ce1_n | output | 1 | Active-low chip select |
| mem_ce2 | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_be_n | output | 2 | Active-low lane enables, bit 1 = upper byte |
| mem_dq_o | output | 16 | Data toward the RAM |
| mem_dq_oe | output | 1 | Enable for the data pad driver |
| mem_dq_i | input | 16 | Data from the RAM |

## Verification
All strobes are decoded from registered state, so each one changes in the cycle after the edge that takes the request. The bench samples on the falling edge and compares every strobe in each of cycles 1 to 12 after acceptance with a per-cycle table: select in 1–10, write strobe in 1–8, driver in 2–9, completion in 11, ready again in 12. The RAM model in the bench raises valid read data only in the tenth cycle of a stable read, so sampling one cycle early returns a marker byte. At each end of a write it counts pulse width, data-setup and address-stable cycles before it stores the enabled lanes.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_WEND,
    ST_DONE
  } ctrl_st_e;

  // round a nanosecond figure up to whole clock cycles
  function automatic int ns2cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    if (clr) cnt_nxt = '0;
    else     cnt_nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_LEN   = 10,
  parameter int WR_LEN   = 8,
  parameter int WEND_LEN = 2,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_we,
  input  logic [CNT_W-1:0] cnt,
  output logic             cnt_clr,
  output logic             req_ready,
  output logic             load,
  output logic             capture,
  output logic             ce_act,
  output logic             oe_n,
  output logic             we_n,
  output logic             dq_oe,
  output logic             done
);

  ctrl_st_e st_q, st_nxt;

  logic rd_last, wr_last, wend_last;
  assign rd_last   = (cnt == CNT_W'(RD_LEN - 1));
  assign wr_last   = (cnt == CNT_W'(WR_LEN - 1));
  assign wend_last = (cnt == CNT_W'(WEND_LEN - 1));

  always_comb begin
    st_nxt = st_q;
    unique case (st_q)
      ST_IDLE: if (req_valid) st_nxt = req_we ? ST_WR : ST_RD;
      ST_RD:   if (rd_last)   st_nxt = ST_DONE;
      ST_WR:   if (wr_last)   st_nxt = ST_WEND;
      ST_WEND: if (wend_last) st_nxt = ST_DONE;
      ST_DONE: st_nxt = ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_nxt;
  end

  assign cnt_clr   = (st_nxt != st_q);
  assign req_ready = (st_q == ST_IDLE);
  assign load      = (st_q == ST_IDLE) && req_valid;
  assign capture   = (st_q == ST_RD) && rd_last;
  assign ce_act    = (st_q == ST_RD) || (st_q == ST_WR) || (st_q == ST_WEND);
  assign oe_n      = (st_q != ST_RD);
  assign we_n      = (st_q != ST_WR);
  assign dq_oe     = ((st_q == ST_WR) && (cnt != '0)) ||
                     ((st_q == ST_WEND) && (cnt == '0));
  assign done      = (st_q == ST_DONE);

  // R1
  idle_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!ce_act && we_n && oe_n && !dq_oe));

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R5
  no_oe_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> oe_n);

  // R6
  drv_after_we_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> (!we_n && !$past(we_n)));

  // R6
  drv_off_after_we_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |=> !dq_oe);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));

endmodule

// File: rtl/sram_ctrl_dp.sv
module sram_ctrl_dp #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              capture,
  input  logic              ce_act,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_be_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (load) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lane_q <= '0;
      else if (capture) lane_q <= mask_q[l] ? mem_dq_i[l*8 +: 8] : 8'h00;
    end
    assign rsp_rdata[l*8 +: 8] = lane_q;
  end

  assign mem_addr = addr_q;
  assign mem_dq_o = wdata_q;
  assign mem_be_n = ce_act ? ~mask_q : {LANES{1'b1}};

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 16,
  parameter int CLK_NS    = 10,
  parameter int T_AA_NS   = 100,
  parameter int T_OE_NS   = 40,
  parameter int T_RC_NS   = 100,
  parameter int T_WP_NS   = 70,
  parameter int T_AW_NS   = 80,
  parameter int T_DW_NS   = 45,
  parameter int T_WR_NS   = 0,
  parameter int T_WC_NS   = 100,
  localparam int LANES    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [LANES-1:0]  mem_be_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int RD_LEN   = max3(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_OE_NS, CLK_NS),
                                 max3(ns2cyc(T_RC_NS, CLK_NS), 1, 1));
  localparam int WR_LEN   = max3(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_AW_NS, CLK_NS),
                                 ns2cyc(T_DW_NS, CLK_NS) + 1);
  localparam int WEND_LEN = max3(1, ns2cyc(T_WR_NS, CLK_NS),
                                 ns2cyc(T_WC_NS, CLK_NS) - WR_LEN);
  localparam int CNT_W    = $clog2(max3(RD_LEN, WR_LEN, WEND_LEN) + 1);

  // asynchronous assertion, synchronous release
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [CNT_W-1:0] cnt;
  logic cnt_clr, load, capture, ce_act;

  sram_ctrl_timer #(.CNT_W(CNT_W)) timer_i (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (cnt_clr),
    .cnt   (cnt)
  );

  sram_ctrl_fsm #(
    .RD_LEN   (RD_LEN),
    .WR_LEN   (WR_LEN),
    .WEND_LEN (WEND_LEN),
    .CNT_W    (CNT_W)
  ) fsm_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_we    (req_we),
    .cnt       (cnt),
    .cnt_clr   (cnt_clr),
    .req_ready (req_ready),
    .load      (load),
    .capture   (capture),
    .ce_act    (ce_act),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .dq_oe     (mem_dq_oe),
    .done      (rsp_done)
  );

  sram_ctrl_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANES  (LANES)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (load),
    .capture   (capture),
    .ce_act    (ce_act),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_mask  (req_mask),
    .mem_dq_i  (mem_dq_i),
    .mem_addr  (mem_addr),
    .mem_be_n  (mem_be_n),
    .mem_dq_o  (mem_dq_o),
    .rsp_rdata (rsp_rdata)
  );

  assign mem_ce1_n = !ce_act;
  assign mem_ce2   = ce_act;

endmodule

// File: tb/sram_ctrl_tb_top.sv
module sram_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  // expected cycle counts derived from the requirements
  localparam int ACC = 10;   // read access cycles
  localparam int WP  = 7;    // minimum write pulse
  localparam int DW  = 5;    // minimum data setup
  localparam int AW  = 8;    // minimum address valid to end of write

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_we;
  logic [17:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_mask;
  logic req_ready, rsp_done;
  logic [15:0] rsp_rdata;
  logic [17:0] mem_addr;
  logic mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0]  mem_be_n;
  logic [15:0] mem_dq_o, mem_dq_i;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_be_n(mem_be_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- RAM model ----------------
  logic [15:0] ram [0:1023];
  logic [15:0] shadow [0:1023];
  logic wa, rc;
  logic wa_prev = 1'b0;
  int wa_cnt = 0, ds_cnt = 0, aw_cnt = 0, rd_cnt = 0;
  logic [17:0] addr_prev = '0;
  logic [15:0] last_d = '0;
  logic [1:0]  last_be = 2'b11;
  logic [9:0]  last_a = '0;

  assign wa = !mem_ce1_n && mem_ce2 && !mem_we_n;
  assign rc = !mem_ce1_n && mem_ce2 && mem_we_n && !mem_oe_n;

  always_comb begin
    for (int l = 0; l < 2; l++)
      mem_dq_i[l*8 +: 8] = (rc && !mem_be_n[l] && rd_cnt >= ACC - 1) ?
                           ram[mem_addr[9:0]][l*8 +: 8] : 8'hEE;
  end

  always @(posedge clk) begin
    if (!mem_oe_n && !mem_we_n) chk(0, "R5 oe/we overlap", 0, 1);
    if (mem_dq_oe && rc) chk(0, "R6 bus contention", 1, 0);
    wa_cnt <= wa ? wa_cnt + 1 : 0;
    ds_cnt <= (wa && mem_dq_oe) ? ds_cnt + 1 : 0;
    aw_cnt <= (!mem_ce1_n && mem_ce2 && mem_addr == addr_prev) ? aw_cnt + 1 : 0;
    rd_cnt <= rc ? rd_cnt + 1 : 0;
    addr_prev <= mem_addr;
    wa_prev <= wa;
    if (wa && mem_dq_oe) begin
      last_d  <= mem_dq_o;
      last_be <= mem_be_n;
      last_a  <= mem_addr[9:0];
    end
    if (wa_prev && !wa) begin
      chk(wa_cnt >= WP, "R5 write pulse width", wa_cnt, WP);
      chk(ds_cnt >= DW, "R6 data setup", ds_cnt, DW);
      chk(aw_cnt + 1 >= AW, "R5 address valid to end", aw_cnt + 1, AW);
      for (int l = 0; l < 2; l++)
        if (!last_be[l]) ram[last_a][l*8 +: 8] <= last_d[l*8 +: 8];
    end
  end

  // ---------------- expected strobes per cycle ----------------
  // vector {ce1_n, ce2, oe_n, we_n, dq_oe, ready, done, be_n[1:0]}
  function automatic logic [8:0] exp_vec(input bit we, input logic [1:0] m, input int k);
    bit act;
    act = (k >= 1 && k <= 10);
    return {!act, act,
            we ? 1'b1 : !act,
            we ? !(k >= 1 && k <= 8) : 1'b1,
            we && (k >= 2 && k <= 9),
            (k >= 12),
            (k == 11),
            act ? ~m : 2'b11};
  endfunction

  task automatic do_op(input bit we, input logic [17:0] a, input logic [15:0] d,
                       input logic [1:0] m, input bit poke, output logic [15:0] rd);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d; req_mask = m;
    @(negedge clk);
    req_valid = 0;
    rd = '0;
    for (int k = 1; k <= 12; k++) begin
      logic [8:0] got;
      if (poke && k == 3) begin
        req_valid = 1; req_we = 1; req_addr = a ^ 18'h00200; req_wdata = 16'h5555; req_mask = 2'b11;
      end
      if (poke && k == 4) req_valid = 0;
      got = {mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe, req_ready, rsp_done, mem_be_n};
      chk(got == exp_vec(we, m, k), "R2 R3 R5 R6 R7 R9 strobes", got, exp_vec(we, m, k));
      if (k >= 1 && k <= 10) chk(mem_addr == a, "R3 R7 address hold", mem_addr, a);
      if (k == 11) rd = rsp_rdata;
      if (k < 12) @(negedge clk);
    end
  endtask

  function automatic logic [17:0] addr_of(input int i);
    if (i == 11) return 18'h3FFFF;
    return {i[7:0], 10'(i * 37)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    for (int j = 0; j < 1024; j++) begin
      ram[j] = 16'(j * 16'h0101) ^ 16'hA5C3;
      shadow[j] = 16'(j * 16'h0101) ^ 16'hA5C3;
    end
    rst_n = 0; req_valid = 0; req_we = 0; req_addr = '0; req_wdata = '0; req_mask = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe, req_ready, rsp_done, mem_be_n}
        == 9'b1_0_1_1_0_1_0_11, "R1 reset standby",
        {mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe, req_ready, rsp_done, mem_be_n}, 9'h16B);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(req_ready && mem_ce1_n && !mem_ce2, "R1 idle standby", {req_ready, mem_ce1_n, mem_ce2}, 3'b110);

    // sweep: writes with each nonzero mask, then reads with every mask
    for (int i = 0; i < 12; i++) begin
      logic [17:0] a;
      a = addr_of(i);
      for (int mi = 0; mi < 3; mi++) begin
        logic [1:0] m;
        logic [15:0] d;
        m = (mi == 0) ? 2'b11 : (mi == 1 ? 2'b01 : 2'b10);
        d = 16'(i * 16'h1357 + mi * 16'h0F21 + 16'h0102);
        do_op(1, a, d, m, 0, rd);
        for (int l = 0; l < 2; l++)
          if (m[l]) shadow[a[9:0]][l*8 +: 8] = d[l*8 +: 8];   // R8
      end
      for (int m = 0; m < 4; m++) begin
        logic [15:0] e;
        do_op(0, a, 16'h0, 2'(m), 0, rd);
        e = {m[1] ? shadow[a[9:0]][15:8] : 8'h00, m[0] ? shadow[a[9:0]][7:0] : 8'h00};
        chk(rd == e, "R4 R8 read data", rd, e);
      end
    end

    // R2 request pulsed while busy must be ignored
    begin
      logic [17:0] a;
      logic [17:0] other;
      logic [15:0] e;
      int extra;
      a = addr_of(5);
      other = a ^ 18'h00200;
      do_op(1, a, 16'hC0DE, 2'b11, 1, rd);
      shadow[a[9:0]] = 16'hC0DE;
      extra = 0;
      for (int k = 0; k < 15; k++) begin
        if (rsp_done) extra++;
        @(negedge clk);
      end
      chk(extra == 0, "R2 ignored request gave no completion", extra, 0);
      do_op(0, other, 16'h0, 2'b11, 0, rd);
      e = shadow[other[9:0]];
      chk(rd == e, "R2 ignored request left memory unchanged", rd, e);
      do_op(0, a, 16'h0, 2'b11, 0, rd);
      chk(rd == 16'hC0DE, "R8 full write readback", rd, 16'hC0DE);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule